// File: doc/BRIEF.md
# Reference Qualification Timer

This block sits beside the failure monitors of one timing reference. It decides two things: whether the loop should follow the reference or hold its last frequency, and whether the reference can still be trusted at all. It takes three monitor flags and a periodic time-base tick. The flags are a single-cycle failure, a coarse-frequency failure and a precise-frequency failure. Each flag first passes through a two-sample agreement filter, so a flag that wobbles at a monitor threshold cannot make the outputs flicker.

The two hard failures, single-cycle and coarse-frequency, put the loop into holdover at once. They also drive an up/down counter that is advanced by the tick. While a hard failure is present the counter climbs by `UP_STEP` on each tick. While none is present it falls by `DN_STEP` on each tick. Because the counter runs in both directions, short failures separated by short clean spells add up instead of restarting a timeout. The reference is disqualified when the counter reaches `UP_STEP*FAIL_TICKS`, and it is requalified only when the counter has drained back to zero. With a 1 ms tick, the defaults give 2.5 s to disqualify and 10 s to requalify. The precise-frequency flag only reports; it affects neither the mode nor the counter.

Top module: `ref_qual_timer`

## Requirements
- R1: `ref_fail_o` is high exactly when at least one of the three filtered flags is high.
- R2: `holdover_o` is high exactly when the filtered single-cycle flag or the filtered coarse-frequency flag is high, and it returns low as soon as both have cleared.
- R3: The precise-frequency flag changes neither `holdover_o` nor the counter, so it never changes `qualified_o`.
- R4: On each tick during holdover, the counter rises by `UP_STEP` and saturates at LIMIT = `UP_STEP*FAIL_TICKS`. `qualified_o` falls on the tick that brings the counter to LIMIT, which from zero is the `FAIL_TICKS`-th such tick.
- R5: On each tick outside holdover, the counter falls by `DN_STEP`, stopping at zero. Failures separated by gaps therefore accumulate.
- R6: A disqualified reference is requalified on the tick that brings the counter to zero, and not before. From saturation this takes LIMIT/`DN_STEP` clean ticks.
- R7: After reset, `qualified_o` is 1, `ref_fail_o` and `holdover_o` are 0, and the counter is 0.
- R8: A filtered flag takes its input's value only after two consecutive clock samples agree. A raw change shows at the outputs after the second rising edge, and a one-cycle pulse has no effect.
- R9: The counter and `qualified_o` change only on cycles where `tick_i` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_i | input | 1 | One-cycle time-base pulse that advances the counter |
| cyc_fail_i | input | 1 | Single-cycle failure flag |
| coarse_fail_i | input | 1 | Coarse-frequency failure flag |
| fine_fail_i | input | 1 | Precise-frequency failure flag (status only) |
| ref_fail_o | output | 1 | Reference failure status |
| holdover_o | output | 1 | Holdover mode request |
| qualified_o | output | 1 | Reference currently qualified |

## Verification
The bench builds the block with `UP_STEP`=4, `DN_STEP`=1 and `FAIL_TICKS`=5, which gives LIMIT=20. At this scale every step to disqualification and every step of the full 20-tick drain back to requalification can be checked tick by tick against an arithmetic model. It also makes a sweep practical: fail bursts of 1 to 4 ticks combined with gaps of 0 to 3 ticks, covering the accumulation, saturation and floor corners. A sweep over all eight flag combinations, single-cycle pulses and held flags with no tick cover the status outputs, the filter and the tick gating.

// File: rtl/ref_qual_timer.sv
module ref_qual_timer #(
  parameter int unsigned UP_STEP    = 4,
  parameter int unsigned DN_STEP    = 1,
  parameter int unsigned FAIL_TICKS = 2500
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick_i,
  input  logic cyc_fail_i,
  input  logic coarse_fail_i,
  input  logic fine_fail_i,
  output logic ref_fail_o,
  output logic holdover_o,
  output logic qualified_o
);

  localparam int unsigned LIMIT = UP_STEP * FAIL_TICKS;
  localparam int unsigned CW    = $clog2(LIMIT + UP_STEP + 1);
  localparam logic [CW-1:0] LIM = CW'(LIMIT);
  localparam logic [CW-1:0] UP  = CW'(UP_STEP);
  localparam logic [CW-1:0] DN  = CW'(DN_STEP);

  logic [2:0] raw, smp, flt, agree;
  logic [CW-1:0] cnt, cnt_nxt;

  assign raw   = {fine_fail_i, coarse_fail_i, cyc_fail_i};
  assign agree = ~(raw ^ smp);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      smp <= '0;
      flt <= '0;
    end else begin
      smp <= raw;
      flt <= (agree & raw) | (~agree & flt);
    end
  end

  assign ref_fail_o = |flt;
  assign holdover_o = flt[0] | flt[1];

  always_comb begin
    cnt_nxt = cnt;
    if (tick_i) begin
      if (holdover_o)
        cnt_nxt = (cnt >= LIM - UP) ? LIM : cnt + UP;
      else
        cnt_nxt = (cnt > DN) ? cnt - DN : '0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt         <= '0;
      qualified_o <= 1'b1;
    end else begin
      cnt <= cnt_nxt;
      if (cnt_nxt == LIM)    qualified_o <= 1'b0;
      else if (cnt_nxt == '0) qualified_o <= 1'b1;
    end
  end

  AST_HOLD_IMPLIES_FAIL: assert property (@(posedge clk) disable iff (!rst_n)
    holdover_o |-> ref_fail_o); // R1
  AST_FINE_NO_MODE: assert property (@(posedge clk) disable iff (!rst_n)
    (flt[2] && !flt[0] && !flt[1]) |-> !holdover_o); // R3
  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= LIM); // R4
  AST_DISQ_AT_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(qualified_o) |-> cnt == LIM); // R4
  AST_REQUAL_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(qualified_o) |-> cnt == '0); // R6
  AST_NO_TICK_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    !tick_i |=> ($stable(cnt) && $stable(qualified_o))); // R9

  for (genvar g = 0; g < 3; g++) begin : g_flt_chk
    AST_FILTER_AGREE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(flt[g]) |-> ($past(raw[g]) && $past(raw[g], 2))); // R8
  end

endmodule

// File: tb/test_ref_qual_timer.sv
module test_ref_qual_timer;
  localparam int UPS = 4, DNS = 1, FT = 5, LIM = UPS * FT;

  logic clk = 1'b0, rst_n = 1'b0, tick = 1'b0;
  logic cyc = 1'b0, coarse = 1'b0, fine = 1'b0;
  logic ref_fail, holdover, qualified;

  int errors = 0, checks = 0;
  int cnt_m = 0;
  bit qual_m = 1'b1;
  bit done = 1'b0;

  always #10 clk = ~clk;

  ref_qual_timer #(.UP_STEP(UPS), .DN_STEP(DNS), .FAIL_TICKS(FT)) i_ref_qual_timer (
    .clk(clk), .rst_n(rst_n), .tick_i(tick),
    .cyc_fail_i(cyc), .coarse_fail_i(coarse), .fine_fail_i(fine),
    .ref_fail_o(ref_fail), .holdover_o(holdover), .qualified_o(qualified));

  task automatic check(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0b expected=%0b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic set_flags(input logic [2:0] v);
    @(negedge clk);
    {fine, coarse, cyc} = v;
    repeat (2) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic do_tick(input string req);
    bit f;
    f = cyc | coarse;
    @(negedge clk);
    tick = 1'b1;
    @(negedge clk);
    tick = 1'b0;
    if (f) cnt_m = (cnt_m + UPS > LIM) ? LIM : cnt_m + UPS;
    else   cnt_m = (cnt_m > DNS) ? cnt_m - DNS : 0;
    if (cnt_m == LIM) qual_m = 1'b0;
    else if (cnt_m == 0) qual_m = 1'b1;
    check(req, qualified, qual_m);
  endtask

  task automatic drain(input string req);
    set_flags(3'b000);
    while (cnt_m != 0) do_tick(req);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R7 qualified", qualified, 1'b1);
    check("R7 ref_fail", ref_fail, 1'b0);
    check("R7 holdover", holdover, 1'b0);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 / R2: all flag combinations, no ticks
    for (int v = 0; v < 8; v++) begin
      set_flags(3'(v));
      check("R1 status", ref_fail, |3'(v));
      check("R2 mode", holdover, v[0] | v[1]);
      check("R9 no tick", qualified, 1'b1);
    end
    set_flags(3'b000);
    check("R2 return", holdover, 1'b0);

    // R8: latency and glitch rejection per flag
    for (int b = 0; b < 3; b++) begin
      @(negedge clk);
      {fine, coarse, cyc} = 3'(1 << b);
      @(negedge clk);
      {fine, coarse, cyc} = 3'b000;
      for (int k = 0; k < 3; k++) begin
        @(negedge clk);
        check("R8 glitch", ref_fail, 1'b0);
      end
      {fine, coarse, cyc} = 3'(1 << b);
      @(negedge clk);
      check("R8 first sample", ref_fail, 1'b0);
      @(negedge clk);
      check("R8 second sample", ref_fail, 1'b1);
      {fine, coarse, cyc} = 3'b000;
      @(negedge clk);
      check("R8 release first", ref_fail, 1'b1);
      @(negedge clk);
      check("R8 release second", ref_fail, 1'b0);
    end

    // R4 then R6: clean disqualify and full drain
    set_flags(3'b001);
    for (int i = 0; i < FT; i++) do_tick("R4 disqualify");
    check("R4 disqualified", qualified, 1'b0);
    for (int i = 0; i < 3; i++) do_tick("R4 saturate");
    set_flags(3'b000);
    for (int i = 0; i < LIM - 1; i++) do_tick("R6 drain");
    check("R6 not yet", qualified, 1'b0);
    do_tick("R6 requalify");
    check("R6 requalified", qualified, 1'b1);

    // R5: burst/gap sweep with accumulation
    for (int n = 1; n <= 4; n++) begin
      for (int g = 0; g <= 3; g++) begin
        for (int r = 0; r < 6; r++) begin
          set_flags(3'b010);
          for (int i = 0; i < n; i++) do_tick("R5 burst");
          set_flags(3'b000);
          for (int i = 0; i < g; i++) do_tick("R5 gap");
        end
        drain("R6 sweep drain");
      end
    end

    // R3: precise flag alone, and mixed with a hard failure
    set_flags(3'b100);
    for (int i = 0; i < 2 * LIM; i++) do_tick("R3 fine only");
    check("R3 mode", holdover, 1'b0);
    check("R3 qualified", qualified, 1'b1);
    set_flags(3'b101);
    for (int i = 0; i < FT; i++) do_tick("R3 mixed");
    set_flags(3'b100);
    for (int i = 0; i < LIM; i++) do_tick("R3 drain with fine");
    check("R3 requalified", qualified, 1'b1);

    // R9: long failure with no ticks leaves the count untouched
    set_flags(3'b001);
    for (int i = 0; i < FT - 1; i++) do_tick("R9 prefill");
    repeat (50) @(negedge clk);
    check("R9 hold", qualified, 1'b1);
    do_tick("R9 next tick");
    check("R9 disqualified", qualified, 1'b0);
    drain("R9 drain");

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule